// File: doc/BRIEF.md
# Double-Buffered DAC Input Latch

This block sits in front of a 12-bit parallel-input digital-to-analog converter and holds the code that the converter sees. A 12-bit data bus is captured into two input registers: an upper register that takes bits 11 down to 8 and a lower register that takes bits 7 down to 0. Each register has its own active-low enable. A load strobe then copies both input registers together into the output register, which drives the converter code. A single active-low write strobe gates every transfer. Without it, nothing moves.

All latches are modelled as level-sensitive enables sampled on the system clock. While the strobes stay low, the registers follow new data on every clock. When the load strobe is low in the same cycle as an input enable, the output takes the freshly presented data in that one cycle. An asynchronous active-low reset forces the output register to the offset-binary bipolar-zero code 12'h800. The reset overrides every other control. It leaves the input registers untouched. A one-cycle update flag marks each cycle in which the output code shows a new value. A parameter selects a transparent variant in which the output follows the next value combinationally. This variant is off by default.

Top module: `dac_input_latch`

## Requirements
- R1: While `wr_n` is high, neither input register nor the output register changes, whatever the other strobes and data do; `code` stays at its previous value.
- R2: On a clock edge where `wr_n` and `hi_en_n` are both low, the upper input register takes `din[11:8]`, which becomes `code[11:8]` at the next load.
- R3: On a clock edge where `wr_n` and `lo_en_n` are both low, the lower input register takes `din[7:0]`, which becomes `code[7:0]` at the next load.
- R4: On a clock edge where `wr_n` and `load_n` are both low, all 12 bits of `code` take the input registers' contents together. They are visible right after that edge, and bit 11 is the MSB.
- R5: While `rst_n` is low, `code` is 12'h800 (offset-binary bipolar zero) at once, without waiting for a clock, and stays there even if `wr_n` and `load_n` are low.
- R6: Reset does not clear the input registers; a load after reset release, with no new capture, outputs the values captured before reset.
- R7: When `load_n` is low in the same cycle as an input enable (with `wr_n` low), `code` takes the newly presented data for that half after that single edge.
- R8: `upd` is high for exactly the one cycle in which `code` first shows a changed value after an edge; a load that leaves `code` unchanged gives no pulse, and `upd` is low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, latches sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output register to bipolar zero |
| wr_n | input | 1 | Active-low master write gate for every transfer |
| hi_en_n | input | 1 | Active-low enable of the upper 4-bit input register |
| lo_en_n | input | 1 | Active-low enable of the lower 8-bit input register |
| load_n | input | 1 | Active-low copy of both input registers into the output register |
| din | input | 12 | Data word, bit 0 LSB, bit 11 MSB, positive true |
| code | output | 12 | Registered converter code |
| upd | output | 1 | One-cycle flag that the output code changed |

## Verification
The assertions assume that the strobes and data are stable around each rising clock edge. They also assume that reset is never asserted and released between two adjacent edges, because a hold or load property spans one edge. The stimulus drives every input on the falling edge and holds `rst_n` low across several edges whenever it is used. Every input register is written once before the first load, so the load properties never compare unknown contents. The sweep walks all sixteen combinations of the four strobes against several data words, and a reference model in the bench predicts each result.

// File: rtl/dil_pkg.sv
package dil_pkg;

    localparam int HI_W_DEF = 4;
    localparam int LO_W_DEF = 8;

    // strobes decoded to active-high qualified transfer requests
    typedef struct packed {
        logic take_hi;
        logic take_lo;
        logic take_out;
    } xfer_t;

    function automatic xfer_t decode_strobes(input logic wr_n, input logic hi_en_n,
                                             input logic lo_en_n, input logic load_n);
        xfer_t x;
        x.take_hi  = !wr_n && !hi_en_n;
        x.take_lo  = !wr_n && !lo_en_n;
        x.take_out = !wr_n && !load_n;
        return x;
    endfunction

endpackage

// File: rtl/dil_field_latch.sv
module dil_field_latch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         take,
    input  logic [W-1:0] d,
    output logic [W-1:0] nxt,
    output logic [W-1:0] q
);

    logic [W-1:0] q_d;
    logic [W-1:0] q_q;

    always_comb begin
        q_d = q_q;
        if (take) begin
            q_d = d;
        end
    end

    // input registers are intentionally outside the reset domain
    always_ff @(posedge clk) begin
        q_q <= q_d;
    end

    assign nxt = q_d;
    assign q   = q_q;

endmodule

// File: rtl/dil_out_stage.sv
module dil_out_stage #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic [W-1:0] src,
    output logic [W-1:0] nxt,
    output logic [W-1:0] code_q,
    output logic         pulse_q
);

    localparam logic [W-1:0] MID_CODE = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic [W-1:0] code;
        logic         pulse;
    } st_t;

    st_t st_d;
    st_t st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (take) begin
            st_d.code  = src;
            st_d.pulse = (src != st_q.code);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{code: MID_CODE, pulse: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign nxt     = st_d.code;
    assign code_q  = st_q.code;
    assign pulse_q = st_q.pulse;

    // R8: a flagged cycle always carries a new code
    p_pulse_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (code_q != $past(code_q)));
    // R8: an unflagged cycle keeps the code
    p_no_pulse_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_q |-> $stable(code_q));

endmodule

// File: rtl/dac_input_latch.sv
module dac_input_latch #(
    parameter int HI_W        = dil_pkg::HI_W_DEF,
    parameter int LO_W        = dil_pkg::LO_W_DEF,
    parameter bit TRANSPARENT = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_n,
    input  logic                 hi_en_n,
    input  logic                 lo_en_n,
    input  logic                 load_n,
    input  logic [HI_W+LO_W-1:0] din,
    output logic [HI_W+LO_W-1:0] code,
    output logic                 upd
);

    import dil_pkg::*;

    localparam int W = HI_W + LO_W;
    localparam logic [W-1:0] MID_CODE = {1'b1, {(W-1){1'b0}}};

    xfer_t        xf;
    logic [HI_W-1:0] hi_nxt, hi_q;
    logic [LO_W-1:0] lo_nxt, lo_q;
    logic [W-1:0]    out_nxt, out_q;
    logic            pulse_q;

    assign xf = decode_strobes(wr_n, hi_en_n, lo_en_n, load_n);

    dil_field_latch #(.W(HI_W)) u_hi (
        .clk (clk),
        .take(xf.take_hi),
        .d   (din[W-1:LO_W]),
        .nxt (hi_nxt),
        .q   (hi_q)
    );

    dil_field_latch #(.W(LO_W)) u_lo (
        .clk (clk),
        .take(xf.take_lo),
        .d   (din[LO_W-1:0]),
        .nxt (lo_nxt),
        .q   (lo_q)
    );

    // flow-through: the output stage sees this cycle's captured halves
    dil_out_stage #(.W(W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (xf.take_out),
        .src    ({hi_nxt, lo_nxt}),
        .nxt    (out_nxt),
        .code_q (out_q),
        .pulse_q(pulse_q)
    );

    generate
        if (TRANSPARENT) begin : g_transp
            assign code = rst_n ? out_nxt : MID_CODE;
            assign upd  = rst_n && (out_nxt != out_q);
        end else begin : g_reg
            assign code = out_q;
            assign upd  = pulse_q;

            // R1: no write gate, no movement anywhere
            p_hold_no_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
                wr_n |=> ($stable(code) && $stable(hi_q) && $stable(lo_q)));
            // R2: upper register capture
            p_hi_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (!wr_n && !hi_en_n) |=> (hi_q == $past(din[W-1:LO_W])));
            // R3: lower register capture
            p_lo_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (!wr_n && !lo_en_n) |=> (lo_q == $past(din[LO_W-1:0])));
            // R4: plain load copies held halves in one step
            p_load_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (!wr_n && !load_n && hi_en_n && lo_en_n) |=> (code == $past({hi_q, lo_q})));
            // R7: full flow-through takes the bus word
            p_flow_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (!wr_n && !load_n && !hi_en_n && !lo_en_n) |=> (code == $past(din)));
            // R5: reset wins over every strobe
            p_reset_mid_r5: assert property (@(posedge clk)
                !rst_n |-> (code == MID_CODE && !upd));
        end
    endgenerate

endmodule

// File: tb/dac_input_latch_tb.sv
module dac_input_latch_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        wr_n = 1'b1, hi_en_n = 1'b1, lo_en_n = 1'b1, load_n = 1'b1;
    logic [11:0] din = '0;
    logic [11:0] code;
    logic        upd;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [3:0]  m_hi;
    logic [7:0]  m_lo;
    logic [11:0] m_code = 12'h800;
    logic        m_upd = 1'b0;

    always #5 clk = ~clk;

    dac_input_latch u_dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .hi_en_n(hi_en_n),
        .lo_en_n(lo_en_n), .load_n(load_n), .din(din), .code(code), .upd(upd)
    );

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive on falling edge, one rising edge, check on next falling edge
    task automatic step(input logic w, input logic h, input logic l, input logic ld,
                        input logic [11:0] d);
        string tag;
        logic [11:0] prev;
        wr_n = w; hi_en_n = h; lo_en_n = l; load_n = ld; din = d;
        prev = m_code;
        if (!w && !h) m_hi = d[11:8];
        if (!w && !l) m_lo = d[7:0];
        if (!w && !ld) m_code = {m_hi, m_lo};
        m_upd = (m_code != prev);
        if (w)                       tag = "R1";
        else if (!ld && (!h || !l))  tag = "R7";
        else if (!ld)                tag = "R4";
        else if (!h)                 tag = "R2";
        else if (!l)                 tag = "R3";
        else                         tag = "R1";
        @(negedge clk);
        chk(tag, code, m_code);
        chk("R8", {11'd0, upd}, {11'd0, m_upd});
    endtask

    initial begin
        #2ms;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #1 rst_n = 1'b0;
        #1 chk("R5", code, 12'h800);
        repeat (3) @(negedge clk);
        chk("R5", code, 12'h800);
        chk("R8", {11'd0, upd}, 12'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // fill both halves without load: output must stay at mid code
        step(1'b0, 1'b0, 1'b0, 1'b1, 12'h3C5);
        chk("R5", code, 12'h800);
        // plain load
        step(1'b0, 1'b1, 1'b1, 1'b0, 12'hFFF);
        chk("R4", code, 12'h3C5);
        // reload same value: no pulse
        step(1'b0, 1'b1, 1'b1, 1'b0, 12'h000);
        chk("R8", {11'd0, upd}, 12'd0);

        // near-exhaustive sweep of strobes against data words
        for (int k = 0; k < 8; k++) begin
            for (int s = 0; s < 16; s++) begin
                logic [11:0] dw;
                dw = 12'((k * 12'h1A7) ^ (s * 12'h093) ^ 12'h5A5);
                step(s[3], s[2], s[1], s[0], dw);
            end
        end

        // reset override with all strobes active
        step(1'b0, 1'b0, 1'b0, 1'b1, 12'hA6B);
        wr_n = 1'b0; hi_en_n = 1'b1; lo_en_n = 1'b1; load_n = 1'b0; din = 12'h111;
        #2 rst_n = 1'b0;
        #1 chk("R5", code, 12'h800);
        @(negedge clk);
        chk("R5", code, 12'h800);
        chk("R8", {11'd0, upd}, 12'd0);
        @(negedge clk);
        chk("R5", code, 12'h800);
        wr_n = 1'b1; load_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        m_code = 12'h800;
        @(negedge clk);
        chk("R5", code, 12'h800);
        // input registers survived reset
        step(1'b0, 1'b1, 1'b1, 1'b0, 12'h000);
        chk("R6", code, 12'hA6B);
        chk("R8", {11'd0, upd}, 12'd1);
        // flow-through on upper half only
        step(1'b0, 1'b0, 1'b1, 1'b0, 12'h4FF);
        chk("R7", code, 12'h46B);
        // write gate high blocks all
        step(1'b1, 1'b0, 1'b0, 1'b0, 12'h999);
        chk("R1", code, 12'h46B);
        step(1'b0, 1'b1, 1'b1, 1'b0, 12'h000);
        chk("R1", code, 12'h46B);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule